// File: doc/BRIEF.md
# Nonvolatile Page Programming Controller

This block sits between a processor's data-space store/load port and two on-chip nonvolatile arrays: a code space and a data flash space. A single 8-bit control/status register selects which space a store or load reaches. It also enables page-buffer loading, automatic erase and programming, and reports supply status and a brownout error. While loading is enabled, each store places one byte into a temporary page buffer. A later store made with loading disabled adds its own byte and starts the page write.

The page write runs through fixed phases: an optional erase of the whole page, a programming wait, then a byte-by-byte commit. Without erase, a committed byte can only clear bits, so the array takes the AND of the old and the new value. A busy output covers the whole sequence. A supply drop while busy aborts the sequence and sets a sticky error flag that only software can clear. The arrays are modelled as simple synchronous memories whose cells start erased (0xFF).

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the register reads 0000_000s binary, where s is the synchronised supply status. busy and mem_rd_valid are low.
- R2: Register layout: bit7 selects the code space (1) or the data flash space (0); bit6 auto-erase; bit5 page load; bit4 program enable; bit3 data flash enable; bit2 error flag; bit1 reads 0; bit0 supply status. Bits 7..3 read back exactly as written.
- R3: Bit0 reads 1 when supply_ok was high and 0 when it was low, one clock edge after supply_ok is sampled.
- R4: With bit7=0 and bit3=0, stores are ignored: no buffer load and no sequence. Loads return 0x00 with mem_rd_valid high.
- R5: A second buffer load to an offset that is already loaded is ignored; the first byte is the one written.
- R6: A store with bit5=0 loads its own byte, if that offset is still free, and starts the page write to the page of its address. The loaded-byte mask is clear after every page write, so a later write commits only its own loads.
- R7: With bit6=1, every byte of the target page becomes 0xFF, except loaded offsets, which take the loaded byte.
- R8: With bit6=0, each loaded offset becomes old AND new, and unloaded offsets keep their value.
- R9: A triggering store with bit4=0 or with the supply status low starts no sequence: busy stays low, the array is unchanged, and the mask is cleared.
- R10: busy is high for exactly (bit6 ? ERASE_CYC : 0) + PROG_CYC + 2*PAGE_BYTES cycles after the triggering store.
- R11: If the supply status is low while busy, the next edge drops busy, aborts the sequence and sets bit2. An abort during the erase or program wait leaves the array unchanged.
- R12: Bit2 is set only by a brownout. Writing 0 to it clears it; writing 1 has no effect.
- R13: Stores and loads presented while busy is high are ignored.
- R14: A load accepted at a clock edge returns its data with mem_rd_valid high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control/status register contents |
| supply_ok | input | 1 | High while the supply is above the minimum programming voltage |
| mem_wr_en | input | 1 | Data-space store strobe |
| mem_rd_en | input | 1 | Data-space load strobe |
| mem_addr | input | ADDR_W | Byte address within the selected space |
| mem_wdata | input | 8 | Store data |
| mem_rdata | output | 8 | Load data, valid with mem_rd_valid |
| mem_rd_valid | output | 1 | Load data valid, one cycle after an accepted load |
| busy | output | 1 | Erase/program sequence in progress |

## Verification
The bench programs every page of both spaces twice, once with erase and once without, using different loaded subsets. It checks the busy length and every byte against a model. A design that ignores the AND rule, or leaves unloaded bytes unerased, fails the readback. A design that keeps the mask across writes disturbs later pages. The bench also attacks a repeated load to one offset, a trigger made with programming disabled or on low supply, and a brownout in the middle of an erase. A wrong design would overwrite the first byte, touch the array, or fail to leave the error flag set. Accesses made during busy and stores to a disabled data space must leave no trace in the array on readback.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int NUM_SPACES = 2;
  localparam int SPACE_DATA = 0;
  localparam int SPACE_CODE = 1;
  localparam int BIT_ERR    = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ERASE,
    PH_PROG,
    PH_FETCH,
    PH_STORE
  } phase_t;

  // software-owned part of the control register, bit7 down to bit3
  typedef struct packed {
    logic sel_code;
    logic auto_erase;
    logic load;
    logic wr_en;
    logic data_en;
  } ctrl_t;
endpackage

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       supply_ok,
  input  logic       err_set,
  output ctrl_t      ctrl,
  output logic       supply_q,
  output logic [7:0] cfg_rdata
);
  logic err_q;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata[1:0];

  always_ff @(posedge clk) begin
    supply_q <= supply_ok;
    if (rst) begin
      ctrl  <= '0;
      err_q <= 1'b0;
    end else begin
      if (cfg_we) ctrl <= cfg_wdata[7:3];
      // hardware set wins over a software clear in the same cycle
      if (err_set)
        err_q <= 1'b1;
      else if (cfg_we && !cfg_wdata[BIT_ERR])
        err_q <= 1'b0;
    end
  end

  assign cfg_rdata = {ctrl, err_q, 1'b0, supply_q};
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [OFF_W-1:0] ld_off,
  input  logic [7:0]       ld_data,
  input  logic             clr,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_loaded
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  take;

  assign take = ld_en && !clr && !mask_q[ld_off];

  always_ff @(posedge clk) begin
    if (rst || clr)
      mask_q <= '0;
    else if (take)
      mask_q[ld_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) slot_q[ld_off] <= ld_data;
  end

  assign rd_data   = slot_q[rd_off];
  assign rd_loaded = mask_q[rd_off];
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ERASE_CYC  = 40,
  parameter int PROG_CYC   = 20,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int MAXC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W  = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             auto_erase,
  input  logic             supply_q,
  input  logic             slot_loaded,
  input  logic [7:0]       slot_data,
  input  logic [7:0]       old_data,
  output logic             busy,
  output logic [OFF_W-1:0] idx,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             clr,
  output logic             err_set
);
  phase_t     ph;
  logic [CNT_W-1:0] cnt;
  logic       erased;
  logic       brownout;
  logic       last_byte;

  assign brownout  = (ph != PH_IDLE) && !supply_q;
  assign last_byte = (idx == OFF_W'(PAGE_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      busy   <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      erased <= 1'b0;
    end else if (brownout) begin
      ph   <= PH_IDLE;
      busy <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          ph     <= auto_erase ? PH_ERASE : PH_PROG;
          busy   <= 1'b1;
          cnt    <= '0;
          idx    <= '0;
          erased <= 1'b0;
        end
        PH_ERASE: if (cnt == CNT_W'(ERASE_CYC - 1)) begin
          ph     <= PH_PROG;
          cnt    <= '0;
          erased <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_PROG: if (cnt == CNT_W'(PROG_CYC - 1)) begin
          ph  <= PH_FETCH;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_FETCH: ph <= PH_STORE;
        PH_STORE: if (last_byte) begin
          ph   <= PH_IDLE;
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          ph  <= PH_FETCH;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // commit: erased page takes buffer or blank, else bits may only clear
  always_comb begin
    wr_en   = (ph == PH_STORE) && supply_q && (erased || slot_loaded);
    wr_data = erased ? (slot_loaded ? slot_data : 8'hFF) : (old_data & slot_data);
  end

  assign clr     = brownout || ((ph == PH_STORE) && last_byte);
  assign err_set = brownout;
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int ERASE_CYC  = 40,
  parameter int PROG_CYC   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              supply_ok,
  input  logic              mem_wr_en,
  input  logic              mem_rd_en,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic              mem_rd_valid,
  output logic              busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  ctrl_t             ctrl;
  logic              supply_q;
  logic              space_ok, permit;
  logic              accept_wr, load_st, trig, start;
  logic              seq_clr, seq_wr, err_set, buf_clr;
  logic [OFF_W-1:0]  seq_idx;
  logic [7:0]        seq_wdata, slot_data, old_data;
  logic              slot_loaded;
  logic [PAGE_W-1:0] page_q;
  logic              space_q;
  logic              rd_sel_q, rd_zero_q, rd_valid_q;
  logic [ADDR_W-1:0] seq_addr, arr_raddr;
  logic [7:0]        rd_arr [NUM_SPACES];

  nvm_ctrl_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .supply_ok (supply_ok),
    .err_set   (err_set),
    .ctrl      (ctrl),
    .supply_q  (supply_q),
    .cfg_rdata (cfg_rdata)
  );

  // routing and store classification
  assign space_ok  = ctrl.sel_code || ctrl.data_en;
  assign permit    = ctrl.wr_en && supply_q;
  assign accept_wr = mem_wr_en && !busy && space_ok;
  assign load_st   = accept_wr && ctrl.load;
  assign trig      = accept_wr && !ctrl.load;
  assign start     = trig && permit;
  assign buf_clr   = seq_clr || (trig && !permit);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      space_q <= 1'b0;
    end else if (start) begin
      page_q  <= mem_addr[ADDR_W-1:OFF_W];
      space_q <= ctrl.sel_code;
    end
  end

  nvm_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (load_st || start),
    .ld_off    (mem_addr[OFF_W-1:0]),
    .ld_data   (mem_wdata),
    .clr       (buf_clr),
    .rd_off    (seq_idx),
    .rd_data   (slot_data),
    .rd_loaded (slot_loaded)
  );

  nvm_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .ERASE_CYC  (ERASE_CYC),
    .PROG_CYC   (PROG_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .auto_erase  (ctrl.auto_erase),
    .supply_q    (supply_q),
    .slot_loaded (slot_loaded),
    .slot_data   (slot_data),
    .old_data    (old_data),
    .busy        (busy),
    .idx         (seq_idx),
    .wr_en       (seq_wr),
    .wr_data     (seq_wdata),
    .clr         (seq_clr),
    .err_set     (err_set)
  );

  // the sequencer borrows the read port while busy
  assign seq_addr  = {page_q, seq_idx};
  assign arr_raddr = busy ? seq_addr : mem_addr;

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    nvm_array #(.ADDR_W(ADDR_W)) u_arr (
      .clk   (clk),
      .we    (seq_wr && (space_q == 1'(s))),
      .waddr (seq_addr),
      .wdata (seq_wdata),
      .raddr (arr_raddr),
      .rdata (rd_arr[s])
    );
  end

  assign old_data = rd_arr[space_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_sel_q   <= 1'b0;
      rd_zero_q  <= 1'b0;
    end else begin
      rd_valid_q <= mem_rd_en && !busy;
      rd_sel_q   <= ctrl.sel_code;
      rd_zero_q  <= !space_ok;
    end
  end

  assign mem_rd_valid = rd_valid_q;
  assign mem_rdata    = rd_zero_q ? 8'h00 : rd_arr[rd_sel_q];
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg_rdata,
  input logic       mem_wr_en,
  input logic       mem_rd_en,
  input logic       mem_rd_valid,
  input logic       busy
);
  assert_busy_from_store_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(mem_wr_en));

  assert_no_start_when_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && mem_wr_en && !cfg_rdata[5] && !cfg_rdata[4]) |=> !busy);

  assert_brownout_abort_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_rdata[0]) |=> (!busy && cfg_rdata[2]));

  assert_err_only_by_brownout_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rdata[2]) |-> $past(busy));

  assert_read_latency_R14: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> ($past(mem_rd_en) && !$past(busy)));

  assert_no_read_while_busy_R13: assert property (@(posedge clk) disable iff (rst)
    busy |=> !mem_rd_valid);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[1]);
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk u_chk (.*);

// File: tb/nvm_prog_ctrl_tb.sv
module nvm_prog_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int AW     = 5;
  localparam int PB     = 4;
  localparam int EC     = 5;
  localparam int PC     = 3;
  localparam int DEPTH  = 1 << AW;
  localparam int NPAGES = DEPTH / PB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          supply_ok = 1'b1;
  logic          mem_wr_en = 1'b0;
  logic          mem_rd_en = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0]    mem_wdata = '0;
  logic [7:0]    mem_rdata;
  logic          mem_rd_valid;
  logic          busy;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  logic [7:0] model [2][DEPTH];
  bit         ldm [PB];
  logic [7:0] ldv [PB];

  always #(CLK_P/2) clk = ~clk;

  nvm_prog_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .ERASE_CYC(EC), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .supply_ok(supply_ok), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd_valid(mem_rd_valid), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit sp, input bit ae, input bit ld,
                                    input bit we, input bit de);
    return {sp, ae, ld, we, de, 3'b000};
  endfunction

  function automatic logic [7:0] pat(input int sp, input int pg, input int off, input int p);
    return 8'((sp * 97 + pg * 31 + off * 13 + p * 7) ^ 8'h5A);
  endfunction

  task automatic cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic st(input int a, input logic [7:0] d);
    mem_wr_en = 1'b1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d, output logic v);
    mem_rd_en = 1'b1; mem_addr = AW'(a);
    @(negedge clk);
    mem_rd_en = 1'b0;
    d = mem_rdata; v = mem_rd_valid;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic mload(input int off, input logic [7:0] d);
    if (!ldm[off]) begin ldm[off] = 1'b1; ldv[off] = d; end
  endtask

  task automatic mapply(input int sp, input int pg, input bit ae);
    for (int o = 0; o < PB; o++) begin
      if (ae) model[sp][pg*PB+o] = ldm[o] ? ldv[o] : 8'hFF;
      else if (ldm[o]) model[sp][pg*PB+o] = model[sp][pg*PB+o] & ldv[o];
      ldm[o] = 1'b0;
    end
  endtask

  task automatic verify_all(input string req);
    logic [7:0] d; logic v;
    for (int sp = 0; sp < 2; sp++) begin
      cfg(mk(sp[0], 0, 0, 0, 1));
      for (int a = 0; a < DEPTH; a++) begin
        rd(a, d, v);
        check(v == 1'b1, {req, " R14 valid"}, v, 1);
        check(d == model[sp][a], req, d, model[sp][a]);
      end
    end
  endtask

  // loads the offsets picked by p, then triggers at offset 0
  task automatic program_page(input int sp, input int pg, input bit ae, input int p);
    int n;
    cfg(mk(sp[0], ae, 1, 1, 1));
    for (int o = 0; o < PB; o++) begin
      if ((pg + o + p) % 3 != 0) begin
        st(pg*PB + o, pat(sp, pg, o, p));
        mload(o, pat(sp, pg, o, p));
      end
    end
    cfg(mk(sp[0], ae, 0, 1, 1));
    st(pg*PB, pat(sp, pg, 9, p));
    mload(0, pat(sp, pg, 9, p));
    wait_idle(n);
    check(n == (ae ? EC : 0) + PC + 2*PB, "R10 busy length", n, (ae ? EC : 0) + PC + 2*PB);
    mapply(sp, pg, ae);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic v; int n;
    for (int sp = 0; sp < 2; sp++)
      for (int a = 0; a < DEPTH; a++) model[sp][a] = 8'hFF;
    for (int o = 0; o < PB; o++) begin ldm[o] = 1'b0; ldv[o] = 8'h00; end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(cfg_rdata == 8'h01, "R1 reset register", cfg_rdata, 8'h01);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(mem_rd_valid == 1'b0, "R1 rd_valid", mem_rd_valid, 0);

    // R2 / R3
    cfg(8'hFB);
    check(cfg_rdata == 8'hF9, "R2 readback", cfg_rdata, 8'hF9);
    supply_ok = 1'b0;
    @(negedge clk);
    check(cfg_rdata[0] == 1'b0, "R3 supply low", cfg_rdata[0], 0);
    supply_ok = 1'b1;
    @(negedge clk);
    check(cfg_rdata[0] == 1'b1, "R3 supply high", cfg_rdata[0], 1);
    cfg(8'h00);
    check(cfg_rdata == 8'h01, "R2 cleared", cfg_rdata, 8'h01);

    // R6 R7 R8 R10: sweep all pages of both spaces, both erase modes
    for (int p = 0; p < 2; p++) begin
      for (int sp = 0; sp < 2; sp++)
        for (int pg = 0; pg < NPAGES; pg++)
          program_page(sp, pg, bit'((pg + p) % 2), p);
      verify_all("R7/R8 sweep");
    end

    // R4: disabled data space
    cfg(mk(0, 0, 0, 1, 0));
    rd(3, d, v);
    check(v == 1'b1 && d == 8'h00, "R4 disabled read", {v, d}, 9'h100);
    cfg(mk(0, 0, 1, 1, 0));
    st(5, 8'h00);
    cfg(mk(0, 0, 0, 1, 0));
    st(4, 8'h00);
    check(busy == 1'b0, "R4 no sequence", busy, 0);
    cfg(mk(0, 0, 0, 1, 1));
    st(6, 8'hFF);
    mload(2, 8'hFF);
    wait_idle(n);
    mapply(0, 1, 0);
    cfg(mk(0, 0, 0, 0, 1));
    rd(5, d, v);
    check(d == model[0][5], "R4 load ignored", d, model[0][5]);
    rd(4, d, v);
    check(d == model[0][4], "R4 store ignored", d, model[0][4]);

    // R5: second load to one offset
    cfg(mk(1, 1, 1, 1, 1));
    st(2*PB + 1, 8'h3C);
    st(2*PB + 1, 8'hC3);
    mload(1, 8'h3C);
    cfg(mk(1, 1, 0, 1, 1));
    st(2*PB, 8'h11);
    mload(0, 8'h11);
    wait_idle(n);
    mapply(1, 2, 1);
    rd(2*PB + 1, d, v);
    check(d == 8'h3C, "R5 first load kept", d, 8'h3C);

    // R6: mask clear after write
    cfg(mk(1, 1, 0, 1, 1));
    st(2*PB + 2, 8'h0F);
    mload(2, 8'h0F);
    wait_idle(n);
    mapply(1, 2, 1);
    rd(2*PB + 1, d, v);
    check(d == 8'hFF, "R6 mask cleared", d, 8'hFF);
    rd(2*PB + 2, d, v);
    check(d == 8'h0F, "R6 trigger byte", d, 8'h0F);

    // R9: programming disabled
    cfg(mk(0, 0, 1, 0, 1));
    st(PB + 1, 8'h00);
    cfg(mk(0, 0, 0, 0, 1));
    st(PB, 8'h00);
    check(busy == 1'b0, "R9 disabled no busy", busy, 0);
    rd(PB, d, v);
    check(d == model[0][PB], "R9 array untouched", d, model[0][PB]);
    cfg(mk(0, 0, 0, 1, 1));
    st(PB + 3, 8'h00);
    mload(3, 8'h00);
    wait_idle(n);
    mapply(0, 1, 0);
    rd(PB + 1, d, v);
    check(d == model[0][PB+1], "R9 mask cleared on abort", d, model[0][PB+1]);
    // R9: low supply at trigger
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    st(3*PB, 8'h00);
    check(busy == 1'b0, "R9 low supply no busy", busy, 0);
    check(cfg_rdata[2] == 1'b0, "R9 no error flag", cfg_rdata[2], 0);
    supply_ok = 1'b1;
    repeat (2) @(negedge clk);

    // R11: brownout during erase
    cfg(mk(1, 1, 1, 1, 1));
    st(5*PB + 1, 8'h00);
    cfg(mk(1, 1, 0, 1, 1));
    st(5*PB, 8'h00);
    repeat (2) @(negedge clk);
    supply_ok = 1'b0;
    wait_idle(n);
    check(n == 2, "R11 abort timing", n, 2);
    check(cfg_rdata[2] == 1'b1, "R11 error set", cfg_rdata[2], 1);
    supply_ok = 1'b1;
    for (int o = 0; o < PB; o++) ldm[o] = 1'b0;
    @(negedge clk);

    // R12: error flag write rules
    cfg(8'h04);
    check(cfg_rdata[2] == 1'b1, "R12 write one keeps", cfg_rdata[2], 1);
    cfg(8'h00);
    check(cfg_rdata[2] == 1'b0, "R12 write zero clears", cfg_rdata[2], 0);
    cfg(8'h04);
    check(cfg_rdata[2] == 1'b0, "R12 write one no set", cfg_rdata[2], 0);

    // R13: accesses during busy
    cfg(mk(0, 1, 0, 1, 1));
    st(6*PB, 8'h22);
    mload(0, 8'h22);
    rd(7*PB, d, v);
    check(v == 1'b0, "R13 read ignored", v, 0);
    st(7*PB, 8'h00);
    wait_idle(n);
    mapply(0, 6, 1);
    @(negedge clk);
    check(busy == 1'b0, "R13 store ignored no sequence", busy, 0);
    verify_all("R11/R13 final");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule